// File: doc/BRIEF.md
# System Exception Pending Controller

This block keeps track of which system exceptions and peripheral interrupts are waiting to be taken, and which one is being handled right now. It holds pending flags for three system exceptions: a non-maskable exception (number 2), a pendable service exception (number 14) and a tick-timer exception (number 15). Next to these it holds one latch per peripheral interrupt line. Line n is reported as exception number n+16.

Software sees one 32-bit control and state word. Writing it sets or clears the system pending flags through dedicated set and clear bits. Reading it returns the pending flags, an "any peripheral interrupt pending" flag, the number of the winning pending exception and the number of the active exception. The winner is chosen in a fixed order: the lowest exception number wins. The core side uses an entry strobe to take the winner and an exit strobe to leave the handler. The block also gives the vector address of the winner, which is four times its number.

Top module: `sysexc_ctrl`

## Requirements
- R1: After reset every pending flag is 0, `active_num` is 0, `pend_num` is 0 and `reg_rdata` reads 0.
- R2: A 1 on `irq_req[n]` in any cycle latches line n pending. The latch holds after the request drops. While any line latch is set, read bit 22 is 1, and a pending line n alone reports `pend_num` = n+16.
- R3: `pend_num` is the lowest-numbered pending exception: 2 (non-maskable), then 14 (pendable service), then 15 (tick), then 16+n for the lowest pending line n. It is 0 when nothing is pending.
- R4: A write with bit 31 set pends exception 2, bit 28 pends 14, and bit 26 pends 15. A 1 on `tick_evt` also pends 15. Bits written as 0 change nothing.
- R5: A write with bit 27 clears exception 14 and bit 25 clears exception 15. When a set bit and its clear bit are written together, the clear wins. A clear of 15 also wins over a `tick_evt` in the same cycle.
- R6: A read returns the pending state of 2, 14 and 15 on bits 31, 28 and 26. Bits 27 and 25 read 0. Bits 17:12 carry `pend_num` and bits 5:0 carry `active_num`. All other bits read 0. Writes to read-only fields have no effect.
- R7: When `exc_entry` is high and `pend_num` is not 0, `active_num` takes that number in the next cycle and the winner's pending flag is cleared. When `exc_entry` is high and nothing is pending, nothing changes.
- R8: `exc_exit` sets `active_num` to 0 in the next cycle. If `exc_entry` takes an exception in the same cycle, the entry wins.
- R9: If software sets a system exception in the same cycle that entry clears it, the flag stays pending. For a peripheral line, entry clears the latch even if its request is high in that cycle. A request that stays high pends the line again one cycle later.
- R10: `pend_vec_addr` equals 4 × `pend_num`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control and state word |
| tick_evt | input | 1 | Tick-timer event, pends exception 15 |
| irq_req | input | NUM_IRQ | Peripheral interrupt requests |
| exc_entry | input | 1 | Core takes the winning pending exception |
| exc_exit | input | 1 | Core returns from the active handler |
| active_num | output | 6 | Number of the exception being handled, 0 if none |
| pend_num | output | 6 | Number of the winning pending exception, 0 if none |
| pend_vec_addr | output | 8 | Vector address of the winner (4 × number) |

## Verification
Two events can hit the same pending flag in one cycle. An entry can clear a flag while a software write sets or clears it, or while a tick event or a held line request sets it again. An entry and an exit can also land on the same edge. Directed steps force each of these collisions on a flag that is the current winner. Random stimulus then repeats them many times, with entries, exits, writes, ticks and requests all overlapping. After every edge, the bench compares the full read word, the active number, the pending number and the vector address with a bench model. That model applies the ordering set out in R5, R8 and R9.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
  // exception number width, fixed by the 6-bit fields of the status word
  localparam int EXC_W     = 6;
  localparam int SYS_SLOTS = 16;
  localparam int NUM_NMI   = 2;
  localparam int NUM_PSV   = 14;
  localparam int NUM_TICK  = 15;

  // status word bit positions (software decodes them)
  localparam int B_NMI_SET  = 31;
  localparam int B_PSV_SET  = 28;
  localparam int B_PSV_CLR  = 27;
  localparam int B_TICK_SET = 26;
  localparam int B_TICK_CLR = 25;
  localparam int B_IRQ_ANY  = 22;
  localparam int F_PEND_LSB = 12;
  localparam int F_ACT_LSB  = 0;

  typedef struct packed {
    logic nmi_set;
    logic psv_set;
    logic psv_clr;
    logic tick_set;
    logic tick_clr;
  } sw_req_t;
endpackage

// File: rtl/sysexc_rst_sync.sv
module sysexc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= 1'b0;
      rst_out_n <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_out_n <= stage_q;
    end
  end
endmodule

// File: rtl/sysexc_pend_bit.sv
// One system pending flag: clear > set > entry acknowledge > hold.
module sysexc_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = set_i | clr_i | ack_i;
    if (clr_i)      pend_d = 1'b0;
    else if (set_i) pend_d = 1'b1;
    else            pend_d = 1'b0;   // acknowledge only
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_o <= 1'b0;
    else if (pend_en) pend_o <= pend_d;
  end
endmodule

// File: rtl/sysexc_irq_bank.sv
// Peripheral line latches: acknowledge beats a concurrent request.
module sysexc_irq_bank #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] req_i,
  input  logic [NUM_IRQ-1:0] ack_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic d;
    logic en;

    always_comb begin
      en = req_i[g] | ack_i[g];
      d  = ~ack_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pend_o[g] <= 1'b0;
      else if (en) pend_o[g] <= d;
    end
  end
endmodule

// File: rtl/sysexc_pick.sv
// Fixed-order selector: lowest set index wins.
module sysexc_pick #(
  parameter int W     = 48,
  parameter int IDX_W = 6
) (
  input  logic [W-1:0]     vec_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    vld_o = |vec_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sysexc_active.sv
module sysexc_active #(
  parameter int EXC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             exit_i,
  input  logic [EXC_W-1:0] win_i,
  output logic [EXC_W-1:0] act_o
);
  logic [EXC_W-1:0] act_d;
  logic             act_en;

  always_comb begin
    act_en = take_i | exit_i;
    act_d  = take_i ? win_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_o <= '0;
    else if (act_en) act_o <= act_d;
  end
endmodule

// File: rtl/sysexc_ctrl.sv
module sysexc_ctrl #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               tick_evt,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               exc_entry,
  input  logic               exc_exit,
  output logic [5:0]         active_num,
  output logic [5:0]         pend_num,
  output logic [7:0]         pend_vec_addr
);
  import sysexc_pkg::*;

  localparam int NUM_EXC = SYS_SLOTS + NUM_IRQ;

  logic               rst_core_n;
  sw_req_t            sw;
  logic               nmi_q, psv_q, tick_q;
  logic [NUM_IRQ-1:0] irq_q, irq_ack;
  logic [NUM_EXC-1:0] pend_vec;
  logic               win_vld;
  logic [EXC_W-1:0]   win_num;
  logic               take;
  logic               unused_wdata;

  sysexc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_out_n(rst_core_n));

  always_comb begin
    sw.nmi_set  = reg_wr_en & reg_wdata[B_NMI_SET];
    sw.psv_set  = reg_wr_en & reg_wdata[B_PSV_SET];
    sw.psv_clr  = reg_wr_en & reg_wdata[B_PSV_CLR];
    sw.tick_set = reg_wr_en & reg_wdata[B_TICK_SET];
    sw.tick_clr = reg_wr_en & reg_wdata[B_TICK_CLR];
  end

  assign unused_wdata = ^{reg_wdata[30:29], reg_wdata[24:0]};
  assign take         = exc_entry & win_vld;

  sysexc_pend_bit u_nmi (
    .clk(clk), .rst_n(rst_core_n), .set_i(sw.nmi_set), .clr_i(1'b0),
    .ack_i(take && (win_num == EXC_W'(NUM_NMI))), .pend_o(nmi_q));

  sysexc_pend_bit u_psv (
    .clk(clk), .rst_n(rst_core_n), .set_i(sw.psv_set), .clr_i(sw.psv_clr),
    .ack_i(take && (win_num == EXC_W'(NUM_PSV))), .pend_o(psv_q));

  sysexc_pend_bit u_tick (
    .clk(clk), .rst_n(rst_core_n), .set_i(sw.tick_set | tick_evt),
    .clr_i(sw.tick_clr),
    .ack_i(take && (win_num == EXC_W'(NUM_TICK))), .pend_o(tick_q));

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ack
    assign irq_ack[g] = take && (win_num == EXC_W'(SYS_SLOTS + g));
  end

  sysexc_irq_bank #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_core_n), .req_i(irq_req), .ack_i(irq_ack),
    .pend_o(irq_q));

  always_comb begin
    pend_vec                          = '0;
    pend_vec[NUM_NMI]                 = nmi_q;
    pend_vec[NUM_PSV]                 = psv_q;
    pend_vec[NUM_TICK]                = tick_q;
    pend_vec[NUM_EXC-1:SYS_SLOTS]     = irq_q;
  end

  sysexc_pick #(.W(NUM_EXC), .IDX_W(EXC_W)) u_pick (
    .vec_i(pend_vec), .vld_o(win_vld), .idx_o(win_num));

  sysexc_active #(.EXC_W(EXC_W)) u_act (
    .clk(clk), .rst_n(rst_core_n), .take_i(take), .exit_i(exc_exit),
    .win_i(win_num), .act_o(active_num));

  assign pend_num      = win_vld ? win_num : '0;
  assign pend_vec_addr = {pend_num, 2'b00};

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[B_NMI_SET]             = nmi_q;
    reg_rdata[B_PSV_SET]             = psv_q;
    reg_rdata[B_TICK_SET]            = tick_q;
    reg_rdata[B_IRQ_ANY]             = |irq_q;
    reg_rdata[F_PEND_LSB +: EXC_W]   = pend_num;
    reg_rdata[F_ACT_LSB  +: EXC_W]   = active_num;
  end
endmodule

// File: rtl/sysexc_ctrl_chk.sv
module sysexc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic       wr_psv_set,
  input logic       wr_psv_clr,
  input logic       rd_nmi,
  input logic       rd_psv,
  input logic       rd_irq_any,
  input logic       exc_entry,
  input logic       exc_exit,
  input logic [5:0] active_num,
  input logic [5:0] pend_num
);
  a_r7_entry_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && pend_num != 6'd0) |=> (active_num == $past(pend_num)));

  a_r7_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && pend_num == 6'd0 && !exc_exit) |=> $stable(active_num));

  a_r8_exit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_exit && !exc_entry) |=> (active_num == 6'd0));

  a_r3_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    rd_nmi |-> (pend_num == 6'd2));

  a_r2_line_number: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_irq_any && !rd_nmi && !rd_psv) |-> (pend_num >= 6'd15));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && wr_psv_clr) |=> !rd_psv);

  a_r4_set_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && wr_psv_set && !wr_psv_clr) |=> rd_psv);
endmodule

bind sysexc_ctrl sysexc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .reg_wr_en(reg_wr_en),
  .wr_psv_set(reg_wdata[28]), .wr_psv_clr(reg_wdata[27]),
  .rd_nmi(reg_rdata[31]), .rd_psv(reg_rdata[28]), .rd_irq_any(reg_rdata[22]),
  .exc_entry(exc_entry), .exc_exit(exc_exit),
  .active_num(active_num), .pend_num(pend_num));

// File: tb/sysexc_ctrl_bench.sv
module sysexc_ctrl_bench;
  localparam int NI = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          tick_evt = 1'b0;
  logic [NI-1:0] irq_req = '0;
  logic          exc_entry = 1'b0;
  logic          exc_exit = 1'b0;
  logic [5:0]    active_num, pend_num;
  logic [7:0]    pend_vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic          m_nmi = 0, m_psv = 0, m_tick = 0;
  logic [NI-1:0] m_irq = '0;
  logic [5:0]    m_act = '0;

  always #2 clk = ~clk;

  sysexc_ctrl #(.NUM_IRQ(NI)) u_sysexc_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_evt(tick_evt), .irq_req(irq_req),
    .exc_entry(exc_entry), .exc_exit(exc_exit), .active_num(active_num),
    .pend_num(pend_num), .pend_vec_addr(pend_vec_addr));

  function automatic logic [5:0] m_pick();
    if (m_nmi)  return 6'd2;
    if (m_psv)  return 6'd14;
    if (m_tick) return 6'd15;
    for (int i = 0; i < NI; i++) if (m_irq[i]) return 6'(16 + i);
    return 6'd0;
  endfunction

  function automatic logic [31:0] m_word();
    logic [31:0] w = '0;
    w[31] = m_nmi; w[28] = m_psv; w[26] = m_tick; w[22] = |m_irq;
    w[17:12] = m_pick(); w[5:0] = m_act;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R6 word"}, reg_rdata, m_word());
    chk({tag, " R3 pend_num"}, 32'(pend_num), 32'(m_pick()));
    chk({tag, " R7 active_num"}, 32'(active_num), 32'(m_act));
    chk({tag, " R10 vec"}, 32'(pend_vec_addr), 32'(m_pick()) * 4);
  endtask

  // apply the current inputs for one edge; model follows R4, R5, R7, R8, R9
  task automatic step(input string tag);
    logic [5:0] win = m_pick();
    logic en = exc_entry && (win != 0);
    logic wr = reg_wr_en;
    logic n_nmi, n_psv, n_tick;
    logic [NI-1:0] n_irq;
    logic [5:0] n_act;
    n_nmi  = (wr && reg_wdata[31]) ? 1'b1 : ((en && win == 2) ? 1'b0 : m_nmi);
    n_psv  = (wr && reg_wdata[27]) ? 1'b0 : (wr && reg_wdata[28]) ? 1'b1
           : ((en && win == 14) ? 1'b0 : m_psv);
    n_tick = (wr && reg_wdata[25]) ? 1'b0 : ((wr && reg_wdata[26]) || tick_evt) ? 1'b1
           : ((en && win == 15) ? 1'b0 : m_tick);
    for (int i = 0; i < NI; i++)
      n_irq[i] = (en && win == 6'(16 + i)) ? 1'b0 : (irq_req[i] ? 1'b1 : m_irq[i]);
    n_act = en ? win : (exc_exit ? 6'd0 : m_act);
    @(posedge clk);
    #1;
    m_nmi = n_nmi; m_psv = n_psv; m_tick = n_tick; m_irq = n_irq; m_act = n_act;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    reg_wr_en = 0; reg_wdata = '0; tick_evt = 0; irq_req = '0;
    exc_entry = 0; exc_exit = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1; reg_wdata = d;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");
    chk("R1 reset word zero", reg_rdata, 32'h0);

    // R2: one-cycle request latches and holds
    idle(); irq_req[5] = 1; step("R2 line5 req");
    idle(); step("R2 line5 held");
    chk("R2 line5 number", 32'(pend_num), 32'd21);
    chk("R10 line5 vector", 32'(pend_vec_addr), 32'd84);
    irq_req[3] = 1; step("R3 line3 lower"); idle();
    chk("R3 line3 wins", 32'(pend_num), 32'd19);

    // R4: set bits and ordering
    wr(32'h0400_0000); step("R4 tick set"); idle();
    chk("R3 tick over lines", 32'(pend_num), 32'd15);
    wr(32'h1000_0000); step("R4 psv set"); idle();
    wr(32'h8000_0000); step("R4 nmi set"); idle();
    chk("R3 nmi first", 32'(pend_num), 32'd2);
    wr(32'h0000_0000); step("R4 zero write"); idle();
    // R5/R6: all-ones write: set+clear pairs clear, read-only fields untouched
    wr(32'hFFFF_FFFF); step("R5 set and clear together"); idle();
    chk("R5 psv cleared", 32'(reg_rdata[28]), 32'd0);
    chk("R6 clear bits read 0", 32'({reg_rdata[27], reg_rdata[25]}), 32'd0);

    // R7: entry takes winner
    exc_entry = 1; step("R7 entry nmi"); idle();
    chk("R7 active is 2", 32'(active_num), 32'd2);
    // R8: entry and exit together, entry wins
    exc_entry = 1; exc_exit = 1; step("R8 entry with exit"); idle();
    chk("R8 entry wins", 32'(active_num), 32'd19);
    exc_exit = 1; step("R8 exit"); idle();
    chk("R8 active zero", 32'(active_num), 32'd0);

    // R5: tick event with tick clear
    tick_evt = 1; wr(32'h0200_0000); step("R5 tick clear beats event"); idle();
    chk("R5 tick cleared", 32'(reg_rdata[26]), 32'd0);

    // R9: software set same cycle as entry clear
    wr(32'h1000_0000); step("R9 psv pend"); idle();
    exc_entry = 1; wr(32'h1000_0000); step("R9 entry with set"); idle();
    chk("R9 psv still pending", 32'(reg_rdata[28]), 32'd1);
    chk("R9 active 14", 32'(active_num), 32'd14);
    wr(32'h0800_0000); step("R9 psv clr"); idle();
    // R9: held line request during its entry
    irq_req[5] = 1; exc_entry = 1; step("R9 line entry with req");
    exc_entry = 0;
    chk("R9 line cleared", 32'(pend_num), 32'd0);
    step("R9 line re-pends"); idle();
    chk("R9 line back", 32'(pend_num), 32'd21);
    exc_entry = 1; step("R7 drain"); idle();
    exc_entry = 1; step("R7 entry nothing pending"); idle();
    chk("R7 idle entry keeps active", 32'(active_num), 32'd21);

    // random phase
    seed_dummy = $urandom(32'd20240611);
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] d = $urandom;
      if ($urandom % 8 != 0) d[31] = 1'b0;
      reg_wr_en = ($urandom % 4 == 0);
      reg_wdata = d;
      tick_evt  = ($urandom % 6 == 0);
      irq_req   = $urandom & $urandom & $urandom;
      exc_entry = ($urandom % 3 == 0);
      exc_exit  = ($urandom % 4 == 0);
      step("R9 random");
    end
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule